// File: doc/BRIEF.md
# Earliest Bank Preparation Finder

This block picks, from all banks of a multi-rank DRAM channel, the banks whose next column burst can begin soonest. A command scheduler uses it when no open-row hit is available to it. Per bank it receives the row state (open or closed) and three "earliest allowed" times: for activate, for precharge and for a column command. It also receives a bitmap of banks that have queued work, the current time, the column time that would follow the previous burst with no gap, and the row-precharge and activate-to-column delays.

After a one-cycle start pulse the block visits one bank per clock, in order of flat bank number. It then raises a one-cycle done pulse. At that point it holds a multi-hot mask of the winning banks and a flag that tells whether the winner's activate can be issued while the data bus is still busy. Banks that can burst with no gap take precedence over banks that can merely activate earliest. All times are unsigned 32-bit values.

Top module: `bank_prep_finder`

## Requirements
- R1: A bank whose bit in `waiting` is 0 never appears in `bank_mask`, even if its timing would make it the winner.
- R2: A bank's activate time is max(activate-allowed, now) when its row is closed (`row_open` bit 0). When its row is open it is max(precharge-allowed, now) + `t_rp`.
- R3: A bank's earliest column time is max(column-allowed, activate time + `t_rcd`). The bank counts as gap-free when that time is less than or equal to `col_target`.
- R4: If at least one waiting bank is gap-free, `bank_mask` at done holds exactly the set of waiting gap-free banks.
- R5: If no waiting bank is gap-free, `bank_mask` at done holds exactly the waiting banks whose activate time equals the minimum over all waiting banks. Ties produce several bits.
- R6: At done, `hidden_prep` is 1 when the activate time of the highest-numbered bank in `bank_mask` is at or below the limit max(`col_target` − `t_rcd`, now). It is 0 when the mask is empty.
- R7: The subtraction `col_target` − `t_rcd` saturates at 0. When `col_target` < `t_rcd`, the limit in R6 is therefore `now`.
- R8: Bank k of rank r has flat number r × BANKS_PER_RANK + k, and maps to bit r × BANKS_PER_RANK + k of `waiting`, `row_open`, `bank_mask`. It also maps to the 32-bit slice at that index of each time vector.
- R9: When `start` is 1 while `busy` is 0, `done` is 1 for exactly one cycle. Counted from the clock edge that takes the start, that cycle follows the NUM_RANKS × BANKS_PER_RANK-th edge.
- R10: A `start` while `busy` is 1 is ignored. Between done and the next accepted start, `bank_mask` and `hidden_prep` stay unchanged even if the inputs change.
- R11: With no waiting bank, done still pulses, with `bank_mask` = 0 and `hidden_prep` = 0.
- R12: After reset, `busy`, `done`, `bank_mask` and `hidden_prep` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| now | input | 32 | Current time, sampled at start |
| col_target | input | 32 | Column time that follows the previous burst without a gap, sampled at start |
| t_rp | input | 32 | Precharge-to-activate delay, sampled at start |
| t_rcd | input | 32 | Activate-to-column delay, sampled at start |
| waiting | input | NB | Bank has queued requests, sampled at start |
| row_open | input | NB | Bank has an open row; held stable during a scan |
| act_ok_at | input | NB×32 | Earliest activate time per bank; held stable during a scan |
| pre_ok_at | input | NB×32 | Earliest precharge time per bank; held stable during a scan |
| col_ok_at | input | NB×32 | Earliest column time per bank; held stable during a scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: result valid |
| bank_mask | output | NB | Multi-hot set of winning banks |
| hidden_prep | output | 1 | Winner's activate fits within bus occupancy |

## Verification
The hardest situation to reach from the ports is a no-gap bank that appears after a lower-numbered bank with a smaller activate time. The result must then throw away the earlier mask instead of merging into it. The stimulus builds this on purpose: a low-numbered bank gets the earliest activate but a late column-allowed time, and higher-numbered banks get slightly later activates that still meet the target. Further cases cover ties on the minimum, an activate time dominated by `now`, a target below the activate-to-column delay, and a second start pulse in the middle of a scan. The expected mask comes from a set-based reading of R4 and R5 rather than from a running scan.

// File: rtl/bpf_pkg.sv
// Package: shared time type and saturating helpers for the bank
// preparation finder. Assumes all times are unsigned and non-wrapping
// within the range used by the scheduler.
package bpf_pkg;
    localparam int TIME_W = 32;
    typedef logic [TIME_W-1:0] time_t;

    function automatic time_t tmax(input time_t a, input time_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic time_t sat_sub(input time_t a, input time_t b);
        return (a > b) ? (a - b) : '0;
    endfunction
endpackage

// File: rtl/bpf_bank_eval.sv
// Module: bpf_bank_eval
// Combinational timing evaluation of one bank: activate time, gap-free
// test against the column target, and hidden-activate test against the
// precomputed limit. Assumes the limit already includes the max with now.
module bpf_bank_eval
    import bpf_pkg::*;
(
    input  logic  row_open_i,
    input  time_t act_ok_i,
    input  time_t pre_ok_i,
    input  time_t col_ok_i,
    input  time_t now_i,
    input  time_t t_rp_i,
    input  time_t t_rcd_i,
    input  time_t col_target_i,
    input  time_t hide_limit_i,
    output time_t act_at_o,
    output logic  seamless_o,
    output logic  hidden_o
);
    time_t col_at;

    // Activate time, column time and the two comparisons.
    always_comb begin
        act_at_o   = row_open_i ? (tmax(pre_ok_i, now_i) + t_rp_i)
                                : tmax(act_ok_i, now_i);
        col_at     = tmax(col_ok_i, act_at_o + t_rcd_i);
        seamless_o = (col_at <= col_target_i);
        hidden_o   = (act_at_o <= hide_limit_i);
    end
endmodule

// File: rtl/bpf_scan_ctrl.sv
// Module: bpf_scan_ctrl
// Sequencer: accepts a start only when idle, steps a bank index once per
// clock over NB banks, then emits a one-cycle done pulse.
module bpf_scan_ctrl #(
    parameter int NB    = 8,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             launch_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    // Start is honoured only while idle.
    assign launch_o = start_i && !busy_o;

    // Index stepping, busy and done generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch_o) begin
                busy_o <= 1'b1;
                idx_o  <= '0;
            end else if (busy_o) begin
                if (idx_o == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bpf_mask_accum.sv
// Module: bpf_mask_accum
// Running selection over visited banks. Gap-free banks win over
// earliest-activate banks; ties on the minimum activate time accumulate.
// The hidden flag follows the last bank added. Assumes clear and step are
// never high together.
module bpf_mask_accum
    import bpf_pkg::*;
#(
    parameter int NB    = 8,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [IDX_W-1:0] idx_i,
    input  time_t            act_at_i,
    input  logic             seamless_i,
    input  logic             hidden_i,
    output logic [NB-1:0]    mask_o,
    output logic             hidden_o
);
    logic          found_q;
    time_t         min_q;
    logic          add, wipe;
    logic [NB-1:0] onehot;

    // Decide whether this bank joins the set and whether the set restarts.
    always_comb begin
        onehot = '0;
        onehot[idx_i] = 1'b1;
        add  = seamless_i || (!found_q && (act_at_i <= min_q));
        wipe = !found_q && (seamless_i || (act_at_i < min_q));
    end

    // Running mask, minimum, gap-free flag and hidden flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '0;
            hidden_o <= 1'b0;
            found_q  <= 1'b0;
            min_q    <= '1;
        end else if (clear_i) begin
            mask_o   <= '0;
            hidden_o <= 1'b0;
            found_q  <= 1'b0;
            min_q    <= '1;
        end else if (step_i && add) begin
            mask_o   <= wipe ? onehot : (mask_o | onehot);
            hidden_o <= hidden_i;
            found_q  <= found_q | seamless_i;
            min_q    <= act_at_i;
        end
    end
endmodule

// File: rtl/bank_prep_finder.sv
// Module: bank_prep_finder (top)
// Finds the banks whose next column burst can start soonest. Scalars and
// the waiting bitmap are captured at start; per-bank timing vectors must
// stay stable from start to done. One bank is evaluated per clock.
module bank_prep_finder
    import bpf_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 4,
    localparam int NB    = NUM_RANKS * BANKS_PER_RANK,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TIME_W-1:0]  now,
    input  logic [TIME_W-1:0]  col_target,
    input  logic [TIME_W-1:0]  t_rp,
    input  logic [TIME_W-1:0]  t_rcd,
    input  logic [NB-1:0]      waiting,
    input  logic [NB-1:0]      row_open,
    input  logic [NB*TIME_W-1:0] act_ok_at,
    input  logic [NB*TIME_W-1:0] pre_ok_at,
    input  logic [NB*TIME_W-1:0] col_ok_at,
    output logic               busy,
    output logic               done,
    output logic [NB-1:0]      bank_mask,
    output logic               hidden_prep
);
    logic             launch;
    logic [IDX_W-1:0] idx;
    time_t            now_q, target_q, trp_q, trcd_q, limit_q;
    logic [NB-1:0]    waiting_q;
    time_t            cur_act_ok, cur_pre_ok, cur_col_ok, act_at;
    logic             cur_open, seamless, hidden;

    bpf_scan_ctrl #(.NB(NB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .launch_o (launch),
        .busy_o   (busy),
        .done_o   (done),
        .idx_o    (idx)
    );

    // Capture scan-wide scalars and the hidden-activate limit at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q     <= '0;
            target_q  <= '0;
            trp_q     <= '0;
            trcd_q    <= '0;
            limit_q   <= '0;
            waiting_q <= '0;
        end else if (launch) begin
            now_q     <= now;
            target_q  <= col_target;
            trp_q     <= t_rp;
            trcd_q    <= t_rcd;
            limit_q   <= tmax(sat_sub(col_target, t_rcd), now);
            waiting_q <= waiting;
        end
    end

    // Select the timing state of the bank under the scan index.
    always_comb begin
        cur_open   = row_open[idx];
        cur_act_ok = act_ok_at[idx*TIME_W +: TIME_W];
        cur_pre_ok = pre_ok_at[idx*TIME_W +: TIME_W];
        cur_col_ok = col_ok_at[idx*TIME_W +: TIME_W];
    end

    bpf_bank_eval u_eval (
        .row_open_i   (cur_open),
        .act_ok_i     (cur_act_ok),
        .pre_ok_i     (cur_pre_ok),
        .col_ok_i     (cur_col_ok),
        .now_i        (now_q),
        .t_rp_i       (trp_q),
        .t_rcd_i      (trcd_q),
        .col_target_i (target_q),
        .hide_limit_i (limit_q),
        .act_at_o     (act_at),
        .seamless_o   (seamless),
        .hidden_o     (hidden)
    );

    bpf_mask_accum #(.NB(NB)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (launch),
        .step_i     (busy && waiting_q[idx]),
        .idx_i      (idx),
        .act_at_i   (act_at),
        .seamless_i (seamless),
        .hidden_i   (hidden),
        .mask_o     (bank_mask),
        .hidden_o   (hidden_prep)
    );
endmodule

// File: rtl/bpf_checker.sv
// Module: bpf_checker
// Protocol and result properties of bank_prep_finder, bound to the top.
// Assumes the waiting bitmap is held stable from start to done.
module bpf_checker #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NB-1:0] waiting,
    input logic          busy,
    input logic          done,
    input logic [NB-1:0] bank_mask,
    input logic          hidden_prep
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_done_after_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(bank_mask) && $stable(hidden_prep)));
    p_mask_waiting_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bank_mask & ~waiting) == '0));
    p_hidden_needs_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hidden_prep) |-> (bank_mask != '0));
endmodule

bind bank_prep_finder bpf_checker #(.NB(NB)) u_bpf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .waiting     (waiting),
    .busy        (busy),
    .done        (done),
    .bank_mask   (bank_mask),
    .hidden_prep (hidden_prep)
);

// File: tb/bank_prep_finder_bench.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares at each done.
module bank_prep_finder_bench;
    localparam int NR  = 2;
    localparam int BPR = 4;
    localparam int NB  = NR * BPR;
    localparam int TW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TW-1:0]     now = '0, col_target = '0, t_rp = '0, t_rcd = '0;
    logic [NB-1:0]     waiting = '0, row_open = '0;
    logic [TW-1:0]     act_a [NB];
    logic [TW-1:0]     pre_a [NB];
    logic [TW-1:0]     col_a [NB];
    logic [NB*TW-1:0]  act_flat, pre_flat, col_flat;
    logic              busy, done, hidden_prep;
    logic [NB-1:0]     bank_mask;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [NB-1:0] m;
        logic          h;
        int            t;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Flatten per-bank arrays (bank i at slice i, R8).
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            act_flat[i*TW +: TW] = act_a[i];
            pre_flat[i*TW +: TW] = pre_a[i];
            col_flat[i*TW +: TW] = col_a[i];
        end
    end

    bank_prep_finder #(.NUM_RANKS(NR), .BANKS_PER_RANK(BPR)) u_bank_prep_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .now(now),
        .col_target(col_target), .t_rp(t_rp), .t_rcd(t_rcd),
        .waiting(waiting), .row_open(row_open),
        .act_ok_at(act_flat), .pre_ok_at(pre_flat), .col_ok_at(col_flat),
        .busy(busy), .done(done), .bank_mask(bank_mask),
        .hidden_prep(hidden_prep)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint mx(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    // Expected result from the set definitions in R2..R7, R11.
    task automatic model(output logic [NB-1:0] m, output logic h);
        longint act [NB];
        longint lim, mn;
        bit any_seam;
        int last;
        m = '0; h = 1'b0; any_seam = 0; mn = 64'h7fffffffffffffff; last = -1;
        lim = mx((col_target > t_rcd) ? longint'(col_target) - longint'(t_rcd) : 0, now);
        for (int i = 0; i < NB; i++) begin
            act[i] = row_open[i] ? mx(pre_a[i], now) + t_rp : mx(act_a[i], now);
            if (waiting[i] && mx(col_a[i], act[i] + t_rcd) <= col_target) begin
                any_seam = 1; m[i] = 1'b1; last = i;
            end
            if (waiting[i] && act[i] < mn) mn = act[i];
        end
        if (!any_seam)
            for (int i = 0; i < NB; i++)
                if (waiting[i] && act[i] == mn) begin m[i] = 1'b1; last = i; end
        if (last >= 0) h = (act[last] <= lim);
    endtask

    task automatic clear_cfg();
        waiting = '0; row_open = '0;
        now = 100; col_target = 120; t_rp = 10; t_rcd = 15;
        for (int i = 0; i < NB; i++) begin act_a[i] = 0; pre_a[i] = 0; col_a[i] = 0; end
    endtask

    // Driver: push expectation, pulse start; optional extra start mid-scan.
    task automatic run(input string tag, input int restart_at);
        exp_t e;
        model(e.m, e.h);
        e.t = cyc; e.tag = tag;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 1; k < NB + 4; k++) begin
            if (k == restart_at) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
    endtask

    // Monitor: compare mask, flag and latency at each done (R9).
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(bank_mask == e.m, {e.tag, " mask"}, bank_mask, e.m);
                chk(hidden_prep == e.h, {e.tag, " hidden R6"}, hidden_prep, e.h);
                chk(cyc - e.t == NB + 1, "R9 latency", cyc - e.t, NB + 1);
            end
        end
    end

    initial begin
        logic [NB-1:0] held_m;
        logic          held_h;
        clear_cfg();
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R12 reset ctrl", {busy, done}, 0);
        chk(bank_mask == 0 && hidden_prep == 0, "R12 reset result", {bank_mask, hidden_prep}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: nothing waiting.
        clear_cfg();
        run("R11 empty", 0);
        chk(bank_mask == 0, "R11 empty mask", bank_mask, 0);

        // R5 R2: closed rows, distinct activates, none gap-free.
        clear_cfg();
        waiting = 8'b0100_1010; act_a[1] = 150; act_a[3] = 130; act_a[6] = 140;
        run("R5 single min", 0);

        // R5 R8: ties on the minimum across both ranks.
        clear_cfg();
        waiting = 8'b0011_0101;
        act_a[0] = 110; act_a[2] = 110; act_a[5] = 110; act_a[4] = 140;
        run("R5 R8 ties", 0);

        // R4 R3: gap-free banks after a lower bank with smaller activate.
        clear_cfg();
        waiting = 8'b1001_0001;
        act_a[0] = 100; col_a[0] = 200; act_a[4] = 104; act_a[7] = 105;
        run("R4 seamless wins", 0);

        // R2: open rows use precharge time plus t_rp.
        clear_cfg();
        waiting = 8'b0010_1000; row_open[3] = 1'b1; pre_a[3] = 90; act_a[5] = 112;
        run("R2 open row", 0);
        clear_cfg();
        waiting = 8'b0010_1000; row_open[3] = 1'b1; pre_a[3] = 130; act_a[5] = 112;
        run("R2 open late", 0);

        // R2 R6: now dominates activate-allowed; hidden true without gap-free.
        clear_cfg();
        now = 110; waiting = 8'b0000_0110; act_a[1] = 50; act_a[2] = 109;
        run("R2 R6 now dominates", 0);

        // R7: target below t_rcd saturates; limit is now.
        clear_cfg();
        col_target = 5; waiting = 8'b0000_0100; act_a[2] = 120;
        run("R7 saturate", 0);

        // R1: non-waiting bank that would be gap-free is excluded.
        clear_cfg();
        waiting = 8'b0000_0100; act_a[2] = 150; act_a[6] = 0;
        run("R1 filter", 0);
        chk(bank_mask[6] == 0, "R1 excluded bank", bank_mask[6], 0);

        // R10: extra start mid-scan is ignored.
        clear_cfg();
        waiting = 8'b1100_0000; act_a[6] = 101; act_a[7] = 101;
        run("R10 restart", 3);

        // R10: result held while inputs change after done.
        held_m = bank_mask; held_h = hidden_prep;
        clear_cfg(); waiting = '1; now = 0;
        repeat (4) @(negedge clk);
        chk(bank_mask == held_m && hidden_prep == held_h, "R10 hold",
            {bank_mask, hidden_prep}, {held_m, held_h});
        chk(sb.size() == 0, "R9 all results seen", sb.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule